// File: doc/BRIEF.md
# Overload Protection and Auto-Restart Sequencer

This block is the digital sequencer that sits behind the feedback and timing-capacitor comparators of a resonant converter controller. It watches a feedback-high flag. An overload or open loop has to outlast two stages before it shuts the converter down. The first is a continuous fixed blanking window counted in clock cycles. The second is an extended blanking stage. In that stage the block repeatedly discharges the feedback capacitor to its 0.5 V level and waits for the node to recharge to the high threshold. Each recharge is one count.

When the configured number of recharges has been seen, the block pulls the feedback node fully to zero. One more high event then stops both power switches through gate-off. The off time is not counted in clock ticks. It is counted in charge and discharge cycles of an external timing capacitor. After that the block releases gate-off and requests a soft start. At any point during extended blanking, the feedback node may fail to come back high within a recovery window. In that case the fault is forgotten and the block returns to normal operation.

Top module: `ovp_seq`

## Requirements
- R1: `fb_high` sampled high on `BLANK_CYC` consecutive clocks moves the block from normal into extended blanking on the next clock, with `min_freq` and `fb_dis` high.
- R2: If `fb_high` is sampled low while blanking, the block returns to normal on the next clock, and the consecutive-high count starts again from zero.
- R3: On entry to extended blanking, `fb_dis` stays high until `fb_low` is sampled high. It is then low from the next clock on.
- R4: While extended blanking is waiting, each sample of `fb_high` adds one to the recharge count and raises `fb_dis` again. Across one full extended episode, `fb_dis` therefore rises `EXT_CYCLES`+1 times.
- R5: Once the recharge count equals `EXT_CYCLES`, the discharge holds until `fb_zero` is seen. The next `fb_high` then enters protection with `gate_off` high. Protection is entered only from extended blanking.
- R6: If `RECOV_CYC` consecutive clocks pass after a discharge release with `fb_high` low, the block returns to normal with every count cleared.
- R7: In protection, `tc_dis` is high until `tc_low` is seen. `tc_chg` is then high until `tc_high` is seen, and the sequence repeats. One charge followed by one discharge counts as one cycle.
- R8: After `RESTART_CYCLES` completed cycles, the block spends exactly one clock in the restarting state with `soft_start` high and `gate_off` low, then returns to normal.
- R9: `min_freq` is high exactly while the block is in extended blanking.
- R10: `tc_chg` and `tc_dis` are never high together, and `fb_dis` is never high together with `tc_chg`.
- R11: Synchronous active-low reset gives mode normal, with `gate_off`, `soft_start`, `min_freq`, `fb_dis`, `tc_chg` and `tc_dis` all low.
- R12: `mode` encodes the state as 0 normal, 1 blanking, 2 extended blanking, 3 protected off, 4 restarting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fb_high | input | 1 | Feedback node above high threshold |
| fb_low | input | 1 | Feedback node at or below 0.5 V level |
| fb_zero | input | 1 | Feedback node near zero |
| tc_high | input | 1 | Timing capacitor reached its high level |
| tc_low | input | 1 | Timing capacitor reached its low level |
| fb_dis | output | 1 | Feedback discharge switch |
| tc_chg | output | 1 | Timing-capacitor charge current enable |
| tc_dis | output | 1 | Timing-capacitor discharge switch |
| gate_off | output | 1 | Stop both power switches |
| soft_start | output | 1 | One-clock soft-start request |
| min_freq | output | 1 | Run the oscillator at minimum-charge-current frequency |
| mode | output | 3 | State code |

## Verification
The bench closes the loop with a simple ramp model of the feedback node and the timing capacitor. It goes after four corner cases.

- A short overload burst must not reach extended blanking. A timer that did not restart would shut down on scattered glitches.
- Removing the overload after the first release must time out back to normal. The next episode must then show the full `EXT_CYCLES`+1 discharges. A design that kept its recharge count would protect too early.
- The discharge count before protection and the charge count before restart are compared with their parameters. An off-by-one in either counter shows up as an extra or missing pulse.
- A cycle-by-cycle reference model flags any clock on which a switch control or the mode differs from the expected value.

// File: rtl/ovp_seq.sv
module ovp_seq #(
  parameter int BLANK_CYC      = 20000,
  parameter int EXT_CYCLES     = 7,
  parameter int RECOV_CYC      = 1200,
  parameter int RESTART_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fb_high,
  input  logic       fb_low,
  input  logic       fb_zero,
  input  logic       tc_high,
  input  logic       tc_low,
  output logic       fb_dis,
  output logic       tc_chg,
  output logic       tc_dis,
  output logic       gate_off,
  output logic       soft_start,
  output logic       min_freq,
  output logic [2:0] mode
);
  localparam int TMAX = (BLANK_CYC > RECOV_CYC) ? BLANK_CYC : RECOV_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int EW   = $clog2(EXT_CYCLES + 1);
  localparam int RW   = $clog2(RESTART_CYCLES + 1);

  typedef enum logic [2:0] {
    S_NORM = 3'd0, S_BLANK = 3'd1, S_EXT = 3'd2, S_PROT = 3'd3, S_RST = 3'd4
  } st_t;

  st_t          st;
  logic [TW-1:0] tmr;
  logic [EW-1:0] ecnt;
  logic [RW-1:0] rcnt;
  logic          dis_ph;

  wire last_ext = (ecnt == EW'(EXT_CYCLES));
  wire fb_done  = last_ext ? fb_zero : fb_low;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_NORM; tmr <= '0; ecnt <= '0; rcnt <= '0; dis_ph <= 1'b0;
    end else begin
      case (st)
        S_NORM:
          if (fb_high) begin st <= S_BLANK; tmr <= TW'(1); end
        S_BLANK:
          if (!fb_high) begin
            st <= S_NORM; tmr <= '0;
          end else if (tmr == TW'(BLANK_CYC - 1)) begin
            st <= S_EXT; tmr <= '0; ecnt <= '0; dis_ph <= 1'b1;
          end else begin
            tmr <= tmr + 1'b1;
          end
        S_EXT:
          if (dis_ph) begin
            if (fb_done) begin dis_ph <= 1'b0; tmr <= '0; end
          end else if (fb_high) begin
            dis_ph <= 1'b1;
            if (last_ext) begin st <= S_PROT; rcnt <= '0; end
            else ecnt <= ecnt + 1'b1;
          end else if (tmr == TW'(RECOV_CYC - 1)) begin
            st <= S_NORM; tmr <= '0; ecnt <= '0;
          end else begin
            tmr <= tmr + 1'b1;
          end
        S_PROT:
          if (dis_ph) begin
            if (tc_low) begin
              if (rcnt == RW'(RESTART_CYCLES)) st <= S_RST;
              else dis_ph <= 1'b0;
            end
          end else if (tc_high) begin
            dis_ph <= 1'b1; rcnt <= rcnt + 1'b1;
          end
        default: begin
          st <= S_NORM; tmr <= '0; ecnt <= '0; rcnt <= '0; dis_ph <= 1'b0;
        end
      endcase
    end
  end

  assign fb_dis     = (st == S_EXT) && dis_ph;
  assign tc_dis     = (st == S_PROT) && dis_ph;
  assign tc_chg     = (st == S_PROT) && !dis_ph;
  assign gate_off   = (st == S_PROT);
  assign soft_start = (st == S_RST);
  assign min_freq   = (st == S_EXT);
  assign mode       = st;
endmodule

// File: rtl/ovp_seq_chk.sv
module ovp_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fb_high,
  input logic       fb_dis,
  input logic       tc_chg,
  input logic       tc_dis,
  input logic       gate_off,
  input logic       soft_start,
  input logic       min_freq,
  input logic [2:0] mode
);
  assert_blank_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd1 && !fb_high) |=> (mode == 3'd0));

  assert_prot_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_off) |-> ($past(mode) == 3'd2));

  assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_start |=> (mode == 3'd0 && !gate_off));

  assert_minfreq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    min_freq |-> (!gate_off && !tc_chg && !tc_dis));

  assert_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(tc_chg && tc_dis) && !(fb_dis && tc_chg));

  assert_reset_R11: assert property (@(posedge clk)
    !rst_n |=> (mode == 3'd0 && !gate_off && !fb_dis && !tc_chg && !tc_dis && !soft_start));
endmodule

bind ovp_seq ovp_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fb_high(fb_high), .fb_dis(fb_dis),
  .tc_chg(tc_chg), .tc_dis(tc_dis), .gate_off(gate_off),
  .soft_start(soft_start), .min_freq(min_freq), .mode(mode)
);

// File: tb/tb_ovp_seq.sv
`timescale 1ns/1ps
module tb_ovp_seq;
  localparam int BLK = 12, EXT = 3, REC = 40, RSC = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fb_high = 0, fb_low = 0, fb_zero = 0, tc_high = 0, tc_low = 1;
  logic fb_dis, tc_chg, tc_dis, gate_off, soft_start, min_freq;
  logic [2:0] mode;

  ovp_seq #(.BLANK_CYC(BLK), .EXT_CYCLES(EXT), .RECOV_CYC(REC), .RESTART_CYCLES(RSC)) dut (
    .clk(clk), .rst_n(rst_n), .fb_high(fb_high), .fb_low(fb_low), .fb_zero(fb_zero),
    .tc_high(tc_high), .tc_low(tc_low), .fb_dis(fb_dis), .tc_chg(tc_chg), .tc_dis(tc_dis),
    .gate_off(gate_off), .soft_start(soft_start), .min_freq(min_freq), .mode(mode));

  always #2 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  int v = 30, tc = 0;
  bit overload = 0;
  int fb_pulses = 0, tc_pulses = 0, ss_pulses = 0;
  bit saw_ext = 0, saw_prot = 0, prev_fbd = 0, prev_tcc = 0;

  // reference model
  int m_st = 0, m_run = 0, m_fault = 0, m_idle = 0, m_tcyc = 0;
  bit m_pull = 0, m_tdis = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_run = 0; m_fault = 0; m_idle = 0; m_tcyc = 0; m_pull = 0; m_tdis = 0;
    end else begin
      case (m_st)
        0: if (fb_high) begin m_st = 1; m_run = 1; end
        1: if (!fb_high) begin m_st = 0; m_run = 0; end
           else begin
             m_run++;
             if (m_run >= BLK) begin m_st = 2; m_run = 0; m_fault = 0; m_pull = 1; end
           end
        2: if (m_pull) begin
             if ((m_fault == EXT) ? fb_zero : fb_low) begin m_pull = 0; m_idle = 0; end
           end else if (fb_high) begin
             m_pull = 1;
             if (m_fault == EXT) begin m_st = 3; m_tdis = 1; m_tcyc = 0; end
             else m_fault++;
           end else begin
             m_idle++;
             if (m_idle >= REC) begin m_st = 0; m_fault = 0; m_idle = 0; end
           end
        3: if (m_tdis) begin
             if (tc_low) begin
               if (m_tcyc == RSC) m_st = 4; else m_tdis = 0;
             end
           end else if (tc_high) begin m_tdis = 1; m_tcyc++; end
        default: begin m_st = 0; m_fault = 0; m_tcyc = 0; m_pull = 0; m_tdis = 0; m_idle = 0; end
      endcase
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // compare, then update plant (away from the active edge)
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
      finish_up();
    end
    if (rst_n) begin
      chk(mode == 3'(m_st), "R12 mode", mode, m_st);
      chk(fb_dis == (m_st == 2 && m_pull), "R3 fb_dis", fb_dis, (m_st == 2 && m_pull));
      chk(tc_dis == (m_st == 3 && m_tdis), "R7 tc_dis", tc_dis, (m_st == 3 && m_tdis));
      chk(tc_chg == (m_st == 3 && !m_tdis), "R7 tc_chg", tc_chg, (m_st == 3 && !m_tdis));
      chk(gate_off == (m_st == 3), "R5 gate_off", gate_off, (m_st == 3));
      chk(soft_start == (m_st == 4), "R8 soft_start", soft_start, (m_st == 4));
      chk(min_freq == (m_st == 2), "R9 min_freq", min_freq, (m_st == 2));
      chk(!(tc_chg && tc_dis) && !(fb_dis && tc_chg), "R10 exclusion", {fb_dis, tc_chg, tc_dis}, 0);
    end
    if (fb_dis && !prev_fbd && mode == 3'd2) fb_pulses++;
    if (tc_chg && !prev_tcc) tc_pulses++;
    if (soft_start) ss_pulses++;
    if (mode == 3'd2) saw_ext = 1;
    if (mode == 3'd3) saw_prot = 1;
    prev_fbd = fb_dis; prev_tcc = tc_chg;
    if (fb_dis) v = (v > 5) ? v - 5 : 0;
    else if (v < (overload ? 50 : 30)) v = v + 3;
    else if (v > (overload ? 50 : 30)) v = v - 3;
    if (tc_dis) tc = (tc > 2) ? tc - 2 : 0;
    else if (tc_chg && tc < 10) tc = tc + 1;
    fb_high = (v >= 45); fb_low = (v <= 5); fb_zero = (v == 0);
    tc_high = (tc >= 10); tc_low = (tc == 0);
  end

  task automatic wait_mode(input int m, input int lim, input string tag);
    int n = 0;
    while (mode != 3'(m) && n < lim) begin @(negedge clk); n++; end
    chk(mode == 3'(m), tag, mode, m);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(mode == 3'd0 && !gate_off && !fb_dis && !tc_chg && !tc_dis && !min_freq,
        "R11 reset state", {mode, gate_off, fb_dis, tc_chg, tc_dis}, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // short burst: must not reach extended blanking
    overload = 1;
    while (!fb_high) @(negedge clk);
    repeat (3) @(negedge clk);
    overload = 0;
    repeat (20) @(negedge clk);
    chk(mode == 3'd0 && !saw_ext, "R2 short burst ignored", {saw_ext, mode}, 0);

    // recovery timeout after first release
    overload = 1;
    wait_mode(2, 200, "R1 enter extended");
    chk(fb_dis && min_freq, "R1 discharge on entry", {fb_dis, min_freq}, 3);
    while (fb_dis) @(negedge clk);
    overload = 0;
    wait_mode(0, REC + 20, "R6 recovery to normal");
    chk(!saw_prot, "R6 no protection", saw_prot, 0);

    // full overload episode: counts must start fresh
    fb_pulses = 0; tc_pulses = 0; ss_pulses = 0;
    overload = 1;
    wait_mode(3, 2000, "R5 protection reached");
    chk(fb_pulses == EXT + 1, "R4 discharge count", fb_pulses, EXT + 1);
    while (!soft_start) @(negedge clk);
    chk(tc_pulses == RSC, "R7 charge cycles", tc_pulses, RSC);
    chk(!gate_off && mode == 3'd4, "R8 restart state", {gate_off, mode}, 4);
    @(negedge clk);
    chk(mode == 3'd0 && !soft_start, "R8 back to normal", mode, 0);
    chk(ss_pulses == 1, "R8 single pulse", ss_pulses, 1);

    // overload persists: second episode then release
    wait_mode(3, 2000, "R5 second protection");
    overload = 0;
    wait_mode(0, 2000, "R8 second restart");
    repeat (60) @(negedge clk);
    chk(mode == 3'd0, "R12 idle after release", mode, 0);
    finish_up();
  end
endmodule